// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It takes the memory from power-up to the point where normal operation can start. A single-cycle `start` pulse begins the work. For each pass, the block captures the mode value and holds auto-refresh off. It then waits a fixed power-up interval and steps through a fixed list of commands. Every list slot is followed by a run of idle cycles. After the second pass the block hands refresh control back to the configured setting and raises `done`.

The mode-register data is derived from three inputs: a two-bit latency field, a clock-speed class flag and a bus-width flag. A nonzero override byte replaces the derived value. The memory sees this data on `mode_o` only in the cycle where the mode-register-set command is on `cmd_o`.

The controller is built around states: `ST_IDLE`, `ST_CONFIG`, `ST_PWR_WAIT`, `ST_ISSUE`, `ST_GAP` and `ST_DONE`. The transitions are:
- `ST_IDLE`/`ST_DONE` → `ST_CONFIG` on `start`.
- `ST_CONFIG` → `ST_PWR_WAIT` always.
- `ST_PWR_WAIT` → `ST_ISSUE` when the timer expires.
- `ST_ISSUE` → `ST_GAP` always.
- `ST_GAP` → `ST_ISSUE` when the timer expires and slots remain in the list.
- `ST_GAP` → `ST_CONFIG` when the list is finished on the first pass.
- `ST_GAP` → `ST_DONE` when the list is finished on the last pass.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, `cmd_o` is NOP (code 0), `mode_o` is zero, `done_o` is low and `refresh_en_o` is low.
- R2: Call the edge that samples `start` in an idle or done state edge S. The block spends one cycle in configuration and then PWRUP_CYCLES cycles waiting. The precharge therefore appears on `cmd_o` in the state after edge S+PWRUP_CYCLES+1.
- R3: Command codes on `cmd_o` are 0 = NOP, 1 = mode-register set, 2 = auto-refresh and 3 = precharge. Each pass plays 20 slots in this order:
  - slot 0: precharge;
  - slots 1 to 16: eight (NOP, refresh) pairs;
  - slot 17: NOP;
  - slot 18: mode-register set;
  - slot 19: NOP.
- R4: Each slot shows its command for one cycle and is followed by GAP_CYCLES idle NOP cycles (default 5). At default settings, non-NOP commands within a pass are therefore 12 cycles apart.
- R5: The full pass (configuration, power-up wait, command list) runs twice back to back. The second precharge appears 2*PWRUP_CYCLES+122 cycles after edge S at default gap settings.
- R6: With no override, a 32-bit bus gives mode data 0x40 for latency 2 and 0x60 for latency 3. Latency 2 is selected by field value 0 in the fast (100 MHz) class, or by field value 1 in the slow (50 MHz) class. Every other field value selects latency 3.
- R7: When `cfg_bus32` is low, the derived mode data is shifted right by one bit, giving 0x20 or 0x30.
- R8: A nonzero `cfg_mode_ovr` is sent unchanged as the mode data, whatever the latency, speed and width inputs are.
- R9: `mode_o` is zero in every cycle where `cmd_o` is not mode-register set.
- R10: `refresh_en_o` is low from reset and throughout a sequence. Once `done_o` rises, it follows `cfg_refresh_en`.
- R11: `done_o` goes low the cycle after an accepted `start`. It rises exactly 2*(PWRUP_CYCLES+1+20*(GAP_CYCLES+1)) cycles after edge S and stays high until the next `start`.
- R12: A `start` pulse that arrives while a sequence is running has no effect on the command stream or on the timing of `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an initialization sequence when idle or done |
| cfg_cas_sel | input | 2 | Latency field, decoded according to the speed class |
| cfg_fast_clk | input | 1 | 1 = 100 MHz class, 0 = 50 MHz class |
| cfg_bus32 | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cfg_mode_ovr | input | MODE_W | Mode-data override; zero selects automatic derivation |
| cfg_refresh_en | input | 1 | Normal auto-refresh setting, applied after done |
| cmd_o | output | 2 | Memory command code |
| mode_o | output | MODE_W | Mode-register data, valid with the mode-register-set command |
| refresh_en_o | output | 1 | Auto-refresh enable toward the refresh scheduler |
| done_o | output | 1 | Initialization complete |

## Verification
The bench targets the speed-dependent latency decode. Field value 0 means latency 2 in one speed class and latency 3 in the other, so a design that ignores the class sends 0x40 where 0x60 is expected. The bench also covers the half-width shift, the override, and the exact cycle of every command across both passes. An off-by-one in the wait or gap counter shifts every later command stamp. A design that skips the second pass leaves ten expected commands unseen when `done_o` rises. The bench pulses `start` in the middle of a sequence; a design that restarts on it issues a precharge at the wrong cycle. The bench also probes `refresh_en_o` on both sides of the `done_o` edge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_MRS = 2'd1,
        CMD_REF = 2'd2,
        CMD_PRE = 2'd3
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONFIG,
        ST_PWR_WAIT,
        ST_ISSUE,
        ST_GAP,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/sdram_mode_calc.sv
module sdram_mode_calc #(
    parameter int MODE_W = 8
) (
    input  logic [1:0]        cas_sel,
    input  logic              fast_clk,
    input  logic              bus32,
    input  logic [MODE_W-1:0] ovr,
    output logic [MODE_W-1:0] mode
);
    localparam logic [MODE_W-1:0] VAL_LAT2 = MODE_W'(8'h40);
    localparam logic [MODE_W-1:0] VAL_LAT3 = MODE_W'(8'h60);

    logic              lat2;
    logic [MODE_W-1:0] wide_val;

    always_comb begin
        // the field meaning depends on the speed class
        lat2     = fast_clk ? (cas_sel == 2'd0) : (cas_sel == 2'd1);
        wide_val = lat2 ? VAL_LAT2 : VAL_LAT3;
        if (ovr != '0) begin
            mode = ovr;
        end else if (bus32) begin
            mode = wide_val;
        end else begin
            mode = wide_val >> 1;
        end
    end
endmodule

// File: rtl/sdram_cmd_list.sv
module sdram_cmd_list
    import sdram_init_pkg::*;
#(
    parameter int REF_PAIRS = 8,
    parameter int IDX_W     = 5
) (
    input  logic [IDX_W-1:0] idx,
    output sdr_cmd_e         cmd
);
    localparam int REF_LAST = 2 * REF_PAIRS;
    localparam int MRS_IDX  = REF_LAST + 2;

    always_comb begin
        if (idx == '0) begin
            cmd = CMD_PRE;
        end else if (idx == IDX_W'(MRS_IDX)) begin
            cmd = CMD_MRS;
        end else if (!idx[0] && (idx <= IDX_W'(REF_LAST))) begin
            cmd = CMD_REF;
        end else begin
            cmd = CMD_NOP;
        end
    end
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int PWRUP_CYCLES = 10000,
    parameter int GAP_CYCLES   = 5,
    parameter int REF_PAIRS    = 8,
    parameter int PASSES       = 2,
    parameter int MODE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cfg_cas_sel,
    input  logic              cfg_fast_clk,
    input  logic              cfg_bus32,
    input  logic [MODE_W-1:0] cfg_mode_ovr,
    input  logic              cfg_refresh_en,
    output logic [1:0]        cmd_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              refresh_en_o,
    output logic              done_o
);
    localparam int LIST_LEN = 2 * REF_PAIRS + 4;
    localparam int IDX_W    = $clog2(LIST_LEN);
    localparam int PASS_W   = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam int CNT_MAX  = (PWRUP_CYCLES > GAP_CYCLES) ? PWRUP_CYCLES : GAP_CYCLES;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [PASS_W-1:0] pass_q, pass_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    logic [MODE_W-1:0] mode_calc;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    sdr_cmd_e          slot_cmd;

    sdram_mode_calc #(.MODE_W(MODE_W)) u_mode (
        .cas_sel  (cfg_cas_sel),
        .fast_clk (cfg_fast_clk),
        .bus32    (cfg_bus32),
        .ovr      (cfg_mode_ovr),
        .mode     (mode_calc)
    );

    sdram_cmd_list #(.REF_PAIRS(REF_PAIRS), .IDX_W(IDX_W)) u_list (
        .idx (idx_q),
        .cmd (slot_cmd)
    );

    sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // next-state and sequencing decisions
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        pass_d   = pass_q;
        mode_d   = mode_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = ST_CONFIG;
                    pass_d  = '0;
                end
            end
            ST_CONFIG: begin
                mode_d   = mode_calc;
                idx_d    = '0;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PWRUP_CYCLES - 1);
                state_d  = ST_PWR_WAIT;
            end
            ST_PWR_WAIT: begin
                if (tmr_expired) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(GAP_CYCLES - 1);
                state_d  = ST_GAP;
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    if (idx_q == IDX_W'(LIST_LEN - 1)) begin
                        if (pass_q == PASS_W'(PASSES - 1)) begin
                            state_d = ST_DONE;
                        end else begin
                            pass_d  = pass_q + 1'b1;
                            state_d = ST_CONFIG;
                        end
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = ST_ISSUE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pass_q  <= '0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pass_q  <= pass_d;
            mode_q  <= mode_d;
        end
    end

    // outputs
    always_comb begin
        cmd_o        = CMD_NOP;
        mode_o       = '0;
        done_o       = 1'b0;
        refresh_en_o = 1'b0;
        unique case (state_q)
            ST_ISSUE: begin
                cmd_o = slot_cmd;
                if (slot_cmd == CMD_MRS) begin
                    mode_o = mode_q;
                end
            end
            ST_DONE: begin
                done_o       = 1'b1;
                refresh_en_o = cfg_refresh_en;
            end
            default: begin
                cmd_o = CMD_NOP;
            end
        endcase
    end
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int GAP_CYCLES = 5,
    parameter int MODE_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cfg_refresh_en,
    input logic [1:0]        cmd_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              refresh_en_o,
    input logic              done_o
);
    logic [7:0] idle_cnt;
    logic       seen_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            seen_cmd <= 1'b0;
        end else if (cmd_o != 2'd0) begin
            idle_cnt <= '0;
            seen_cmd <= 1'b1;
        end else if (idle_cnt != 8'hFF) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    AST_MODE_ONLY_MRS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'd1) |-> (mode_o == '0)); // R9
    AST_NO_CMD_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cmd_o == 2'd0)); // R9
    AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o != 2'd0) && seen_cmd) |-> (idle_cnt >= 8'(GAP_CYCLES))); // R4
    AST_REF_OFF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !refresh_en_o); // R10
    AST_REF_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (refresh_en_o == cfg_refresh_en)); // R10
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> done_o); // R11
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start) |=> !done_o); // R11
endmodule

bind sdram_init_seq sdram_init_chk #(.GAP_CYCLES(GAP_CYCLES), .MODE_W(MODE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .cfg_refresh_en (cfg_refresh_en),
    .cmd_o          (cmd_o),
    .mode_o         (mode_o),
    .refresh_en_o   (refresh_en_o),
    .done_o         (done_o)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;
    localparam int PW   = 40;
    localparam int GAP  = 5;
    localparam int SLOT = GAP + 1;
    localparam int PASS_LEN = PW + 1 + 20 * SLOT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cfg_cas_sel = 2'd0;
    logic       cfg_fast_clk = 1'b0;
    logic       cfg_bus32 = 1'b0;
    logic [7:0] cfg_mode_ovr = 8'd0;
    logic       cfg_refresh_en = 1'b0;
    logic [1:0] cmd_o;
    logic [7:0] mode_o;
    logic       refresh_en_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    int pcnt = 0;
    int t0 = 0;

    typedef struct {
        logic [1:0] cmd;
        logic [7:0] mode;
        int         off;
    } item_t;
    item_t exp_q[$];

    sdram_init_seq #(.PWRUP_CYCLES(PW), .GAP_CYCLES(GAP)) u_sdram_init_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .cfg_cas_sel    (cfg_cas_sel),
        .cfg_fast_clk   (cfg_fast_clk),
        .cfg_bus32      (cfg_bus32),
        .cfg_mode_ovr   (cfg_mode_ovr),
        .cfg_refresh_en (cfg_refresh_en),
        .cmd_o          (cmd_o),
        .mode_o         (mode_o),
        .refresh_en_o   (refresh_en_o),
        .done_o         (done_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) pcnt <= pcnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop expected commands as the design issues them
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_o != 2'd0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12 unexpected command", int'(cmd_o), 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(cmd_o == it.cmd, "R3 command order", int'(cmd_o), int'(it.cmd));
                    check((pcnt - t0) == it.off, "R4/R5 command cycle R2", pcnt - t0, it.off);
                    if (it.cmd == 2'd1)
                        check(mode_o == it.mode, "R6 R7 R8 mode data", int'(mode_o), int'(it.mode));
                end
            end else if (mode_o != 8'd0) begin
                check(1'b0, "R9 mode data outside MRS", int'(mode_o), 0);
            end
        end
    end

    function automatic logic [7:0] exp_mode(input logic [1:0] cas, input logic fast,
                                            input logic b32, input logic [7:0] ovr);
        logic [7:0] v;
        bit l2;
        l2 = fast ? (cas == 2'd0) : (cas == 2'd1);
        v  = l2 ? 8'h40 : 8'h60;
        if (!b32) v = v >> 1;
        if (ovr != 8'd0) v = ovr;
        return v;
    endfunction

    function automatic logic [1:0] exp_slot(input int e);
        if (e == 0) return 2'd3;
        if (e == 18) return 2'd1;
        if ((e % 2 == 0) && e >= 2 && e <= 16) return 2'd2;
        return 2'd0;
    endfunction

    task automatic run_seq(input logic [1:0] cas, input logic fast, input logic b32,
                           input logic [7:0] ovr, input logic refen, input bit poke);
        logic [7:0] m;
        @(negedge clk);
        cfg_cas_sel = cas; cfg_fast_clk = fast; cfg_bus32 = b32;
        cfg_mode_ovr = ovr; cfg_refresh_en = refen;
        m = exp_mode(cas, fast, b32, ovr);
        for (int p = 0; p < 2; p++) begin
            for (int e = 0; e < 20; e++) begin
                item_t it;
                it.cmd  = exp_slot(e);
                it.mode = (it.cmd == 2'd1) ? m : 8'd0;
                it.off  = p * PASS_LEN + PW + 1 + SLOT * e;
                if (it.cmd != 2'd0) exp_q.push_back(it);
            end
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = pcnt;
        check(done_o == 1'b0, "R11 done low after start", int'(done_o), 0);
        check(refresh_en_o == 1'b0, "R10 refresh off in sequence", int'(refresh_en_o), 0);
        if (poke) begin
            repeat (50) @(negedge clk);
            start = 1'b1;                  // R12: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while ((pcnt - t0) < 2 * PASS_LEN - 1) @(negedge clk);
        check(done_o == 1'b0, "R11 done low before end", int'(done_o), 0);
        check(refresh_en_o == 1'b0, "R10 refresh off before done", int'(refresh_en_o), 0);
        @(negedge clk);
        check(done_o == 1'b1, "R11 done at end of second pass", int'(done_o), 1);
        check(refresh_en_o == refen, "R10 refresh restored", int'(refresh_en_o), int'(refen));
        check(exp_q.size() == 0, "R5 both passes issued", exp_q.size(), 0);
        repeat (7) @(negedge clk);
        check(done_o == 1'b1, "R11 done held", int'(done_o), 1);
        check(cmd_o == 2'd0, "R9 NOP while done", int'(cmd_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_o == 2'd0, "R1 reset cmd", int'(cmd_o), 0);
        check(mode_o == 8'd0, "R1 reset mode", int'(mode_o), 0);
        check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
        check(refresh_en_o == 1'b0, "R1 reset refresh", int'(refresh_en_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_seq(2'd0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0);  // R6 fast, field 0 -> 0x40
        run_seq(2'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1);  // R6 slow, field 0 -> 0x60; R12 poke
        run_seq(2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);  // R7 slow lat2 16-bit -> 0x20
        run_seq(2'd1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);  // R7 fast lat3 16-bit -> 0x30
        run_seq(2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);  // R6 other field -> 0x60
        run_seq(2'd0, 1'b1, 1'b0, 8'h55, 1'b1, 1'b1);  // R8 override
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule